// File: doc/BRIEF.md
# Protection Region Permission Checker

This block keeps a small set of programmable protection regions and judges every bus access against them. An access arrives with its address, a read/write flag and a privileged/unprivileged flag. One cycle later the block answers with a response strobe and an allow-or-fault flag. A region applies to an address when it is enabled and the address lies inside the region's naturally aligned power-of-two span. When more than one enabled region covers an address, the region with the highest number decides the permission. An address that no enabled region covers is refused.

Software configures the regions through a small write window. One word selects a region. A base word and a size/attribute word then program that region. The size/attribute word can also be written one halfword at a time. Extra base and size/attribute word pairs follow the first pair. A base word that carries a retarget flag picks the region by itself, so a single burst of consecutive words can program several regions.

Each refused access records its address, its cause and its direction in status outputs. A sticky flag shows that at least one refusal has happened.

Top module: `prot_region_guard`

## Requirements
- R1: After reset every region is disabled, `resp_valid` and `fault_seen` are 0, and `fault_addr` is 0.
- R2: An access sampled with `acc_valid` high at clock edge k gives `resp_valid` high after edge k+1, together with its `resp_fault`. `resp_valid` is low in every cycle that follows an idle cycle.
- R3: A region covers an address when its enable bit is 1 and the address bits above bit N match its base, where N is the 5-bit size code and the span is 2^(N+1) bytes. Codes below 4 act as 4. An access that no enabled region covers faults with cause 2'b10.
- R4: When several enabled regions cover an address, the highest-numbered region's permission code applies.
- R5: Permission codes 3'b000 and 3'b100 refuse every access at both privilege levels, with cause 2'b01.
- R6: Code 3'b001 allows privileged reads and writes and refuses every unprivileged access.
- R7: Code 3'b010 allows privileged reads and writes and unprivileged reads, and refuses unprivileged writes.
- R8: Code 3'b011 allows all reads and writes at both privilege levels.
- R9: Code 3'b101 allows only privileged reads. Codes 3'b110 and 3'b111 allow reads and refuse writes at both levels.
- R10: Window words, at word-aligned byte offsets: 0x0 holds the region select in bits 3:0. 0x4 holds the base, with the address in bits 31:5. 0x8 holds the size/attribute word, where byte lane 0 carries enable (bit 0) and size code (bits 5:1), and byte lane 2 carries the permission code (bits 18:16). The low halfword is written with `cfg_be`=4'b0011. The halfword at +0xA is written as offset 0x8 with `cfg_be`=4'b1100. Each halfword write leaves the other half unchanged. The select and base words need `cfg_be`=4'hF.
- R11: A base word with bit 4 set programs the region given by bits 3:0 and also loads that number into the region select. The word pairs at 0xC/0x10, 0x14/0x18 and 0x1C/0x20 act exactly like 0x4/0x8.
- R12: A fault loads `fault_addr`, `fault_cause` (2'b01 permission, 2'b10 no region) and `fault_write` at the same edge as `resp_fault`, and sets `fault_seen`, which stays set. An allowed access leaves all of these unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_addr | input | 6 | Window byte offset (word aligned) |
| cfg_be | input | 4 | Byte-lane enables |
| cfg_wdata | input | 32 | Window write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged requester |
| resp_valid | output | 1 | Response strobe |
| resp_fault | output | 1 | 1 = access refused |
| fault_seen | output | 1 | Sticky: a fault has occurred |
| fault_cause | output | 2 | Cause of last fault |
| fault_addr | output | ADDR_W | Address of last fault |
| fault_write | output | 1 | Direction of last fault |

## Verification
A window write driven at one falling edge is stored at the next rising edge, so the very next access already sees it. An access driven at a falling edge is registered at the following rising edge. At that same edge `resp_fault` and the fault status are loaded. The bench therefore drives on one falling edge and samples all results on the next falling edge, half a period after they were loaded. It returns the access inputs to idle before issuing the next stimulus.

// File: rtl/prg_pkg.sv
package prg_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'b00,
      CAUSE_PERM    = 2'b01,
      CAUSE_NOMATCH = 2'b10
   } cause_e;

   localparam int SIZE_W    = 5;
   localparam int PERM_W    = 3;
   localparam int IDX_FIELD = 4;

   // Permission code decoded per requester level and direction.
   function automatic logic perm_allows(input logic [PERM_W-1:0] code,
                                        input logic priv,
                                        input logic wr);
      logic ok;
      case (code)
         3'b001:         ok = priv;
         3'b010:         ok = priv || !wr;
         3'b011:         ok = 1'b1;
         3'b101:         ok = priv && !wr;
         3'b110, 3'b111: ok = !wr;
         default:        ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/prg_regfile.sv
module prg_regfile
   import prg_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int ALIAS_SLOTS = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cfg_we,
   input  logic [5:0]                             cfg_addr,
   input  logic [3:0]                             cfg_be,
   input  logic [31:0]                            cfg_wdata,
   output logic [NUM_REGIONS-1:0]                 reg_en,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     reg_base,
   output logic [NUM_REGIONS-1:0][SIZE_W-1:0]     reg_size,
   output logic [NUM_REGIONS-1:0][PERM_W-1:0]     reg_perm
);
   localparam int         IDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
   localparam logic [4:0] NREG      = 5'(NUM_REGIONS);
   localparam logic [3:0] LAST_WORD = 4'(2 * ALIAS_SLOTS);

   logic [3:0]           word;
   logic                 aligned;
   logic                 hit_sel;
   logic                 hit_base;
   logic                 hit_size;
   logic [IDX_FIELD-1:0] req_idx;
   logic                 req_ok;
   logic                 retarget;
   logic                 base_we;
   logic [IDX_W-1:0]     sel_q;
   logic [IDX_W-1:0]     tgt;

   assign word     = cfg_addr[5:2];
   assign aligned  = (cfg_addr[1:0] == 2'b00);
   assign hit_sel  = cfg_we && aligned && (word == 4'd0) && (cfg_be == 4'hF);
   assign hit_base = cfg_we && aligned && word[0] && (word < LAST_WORD) && (cfg_be == 4'hF);
   assign hit_size = cfg_we && aligned && !word[0] && (word != 4'd0) && (word <= LAST_WORD);
   assign req_idx  = cfg_wdata[IDX_FIELD-1:0];
   assign req_ok   = ({1'b0, req_idx} < NREG);
   assign retarget = hit_base && cfg_wdata[4] && req_ok;
   assign base_we  = hit_base && (!cfg_wdata[4] || req_ok);
   assign tgt      = retarget ? req_idx[IDX_W-1:0] : sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (hit_sel && req_ok) begin
         sel_q <= req_idx[IDX_W-1:0];
      end else if (retarget) begin
         sel_q <= req_idx[IDX_W-1:0];
      end
   end

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      logic mine;
      assign mine = (tgt == IDX_W'(r));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            reg_base[r] <= '0;
            reg_en[r]   <= 1'b0;
            reg_size[r] <= '0;
            reg_perm[r] <= '0;
         end else begin
            if (base_we && mine) begin
               reg_base[r] <= {cfg_wdata[ADDR_W-1:5], 5'b0};
            end
            if (hit_size && mine && cfg_be[0]) begin
               reg_en[r]   <= cfg_wdata[0];
               reg_size[r] <= cfg_wdata[5:1];
            end
            if (hit_size && mine && cfg_be[2]) begin
               reg_perm[r] <= cfg_wdata[18:16];
            end
         end
      end
   end

   AST_RETARGET_LOADS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      retarget |=> (sel_q == $past(req_idx[IDX_W-1:0]))); // R11

   AST_SEL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(sel_q)); // R10

   AST_IDLE_KEEPS_REGIONS: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(reg_en) && $stable(reg_perm))); // R10

endmodule

// File: rtl/prg_region_match.sv
module prg_region_match
   import prg_pkg::*;
#(
   parameter int NUM_REGIONS   = 8,
   parameter int ADDR_W        = 32,
   parameter int MIN_SIZE_CODE = 4
) (
   input  logic [ADDR_W-1:0]                      addr,
   input  logic [NUM_REGIONS-1:0]                 reg_en,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     reg_base,
   input  logic [NUM_REGIONS-1:0][SIZE_W-1:0]     reg_size,
   output logic [NUM_REGIONS-1:0]                 hit
);
   localparam int MAX_CODE = ADDR_W - 1;

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
      logic [ADDR_W-1:0] keep;
      int                n_eff;

      always_comb begin
         n_eff = int'(reg_size[r]);
         if (n_eff < MIN_SIZE_CODE) n_eff = MIN_SIZE_CODE;
         if (n_eff > MAX_CODE)      n_eff = MAX_CODE;
         for (int i = 0; i < ADDR_W; i++) begin
            keep[i] = (i > n_eff);
         end
      end

      assign hit[r] = reg_en[r] && (((addr ^ reg_base[r]) & keep) == '0);
   end

endmodule

// File: rtl/prg_perm_select.sv
module prg_perm_select
   import prg_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter bit HIGH_WINS   = 1'b1
) (
   input  logic [NUM_REGIONS-1:0]              hit,
   input  logic [NUM_REGIONS-1:0][PERM_W-1:0]  reg_perm,
   input  logic                                priv,
   input  logic                                wr,
   output logic                                any_hit,
   output logic [PERM_W-1:0]                   win_perm,
   output logic                                allow
);
   if (HIGH_WINS) begin : g_high
      always_comb begin
         any_hit  = 1'b0;
         win_perm = '0;
         for (int r = 0; r < NUM_REGIONS; r++) begin
            if (hit[r]) begin
               any_hit  = 1'b1;
               win_perm = reg_perm[r];
            end
         end
      end
   end else begin : g_low
      always_comb begin
         any_hit  = 1'b0;
         win_perm = '0;
         for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (hit[r]) begin
               any_hit  = 1'b1;
               win_perm = reg_perm[r];
            end
         end
      end
   end

   assign allow = any_hit && perm_allows(win_perm, priv, wr);

endmodule

// File: rtl/prot_region_guard.sv
module prot_region_guard
   import prg_pkg::*;
#(
   parameter int NUM_REGIONS   = 8,
   parameter int ADDR_W        = 32,
   parameter int ALIAS_SLOTS   = 4,
   parameter int MIN_SIZE_CODE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_priv,
   output logic              resp_valid,
   output logic              resp_fault,
   output logic              fault_seen,
   output logic [1:0]        fault_cause,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              fault_write
);
   if (NUM_REGIONS < 1 || NUM_REGIONS > 16) begin : g_bad_regions
      $error("NUM_REGIONS must lie in 1..16");
   end
   if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 6..32");
   end
   if (ALIAS_SLOTS < 1 || ALIAS_SLOTS > 4) begin : g_bad_alias
      $error("ALIAS_SLOTS must lie in 1..4");
   end
   if (MIN_SIZE_CODE < 4 || MIN_SIZE_CODE > ADDR_W - 1) begin : g_bad_min
      $error("MIN_SIZE_CODE out of range");
   end

   logic [NUM_REGIONS-1:0]               reg_en;
   logic [NUM_REGIONS-1:0][ADDR_W-1:0]   reg_base;
   logic [NUM_REGIONS-1:0][SIZE_W-1:0]   reg_size;
   logic [NUM_REGIONS-1:0][PERM_W-1:0]   reg_perm;
   logic [NUM_REGIONS-1:0]               hit;
   logic                                 any_hit;
   logic [PERM_W-1:0]                    win_perm;
   logic                                 allow;

   prg_regfile #(
      .NUM_REGIONS (NUM_REGIONS),
      .ADDR_W      (ADDR_W),
      .ALIAS_SLOTS (ALIAS_SLOTS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .reg_en    (reg_en),
      .reg_base  (reg_base),
      .reg_size  (reg_size),
      .reg_perm  (reg_perm)
   );

   prg_region_match #(
      .NUM_REGIONS   (NUM_REGIONS),
      .ADDR_W        (ADDR_W),
      .MIN_SIZE_CODE (MIN_SIZE_CODE)
   ) u_match (
      .addr     (acc_addr),
      .reg_en   (reg_en),
      .reg_base (reg_base),
      .reg_size (reg_size),
      .hit      (hit)
   );

   prg_perm_select #(
      .NUM_REGIONS (NUM_REGIONS),
      .HIGH_WINS   (1'b1)
   ) u_perm (
      .hit      (hit),
      .reg_perm (reg_perm),
      .priv     (acc_priv),
      .wr       (acc_write),
      .any_hit  (any_hit),
      .win_perm (win_perm),
      .allow    (allow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_fault  <= 1'b0;
         fault_seen  <= 1'b0;
         fault_cause <= CAUSE_NONE;
         fault_addr  <= '0;
         fault_write <= 1'b0;
      end else begin
         resp_valid <= acc_valid;
         if (acc_valid) begin
            resp_fault <= !allow;
            if (!allow) begin
               fault_seen  <= 1'b1;
               fault_cause <= any_hit ? CAUSE_PERM : CAUSE_NOMATCH;
               fault_addr  <= acc_addr;
               fault_write <= acc_write;
            end
         end
      end
   end

   AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> resp_valid); // R2

   AST_NO_RESP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !resp_valid); // R2

   AST_UNCOVERED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !any_hit) |=> (resp_fault && fault_cause == CAUSE_NOMATCH)); // R3

   AST_DENY_CODES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && any_hit && (win_perm == 3'b000 || win_perm == 3'b100)) |=> resp_fault); // R5

   AST_FULL_CODE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && any_hit && win_perm == 3'b011) |=> !resp_fault); // R8

   AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault) |-> (fault_seen && fault_addr == $past(acc_addr))); // R12

   AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fault_seen |=> fault_seen); // R12

   AST_ALLOW_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && allow) |=> ($stable(fault_addr) && $stable(fault_cause))); // R12

endmodule

// File: tb/prot_region_guard_test.sv
module prot_region_guard_test;
   localparam int ADDR_W = 32;
   localparam int NVEC   = 34;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [5:0]        cfg_addr = '0;
   logic [3:0]        cfg_be = '0;
   logic [31:0]       cfg_wdata = '0;
   logic              acc_valid = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic              acc_write = 1'b0;
   logic              acc_priv = 1'b0;
   logic              resp_valid;
   logic              resp_fault;
   logic              fault_seen;
   logic [1:0]        fault_cause;
   logic [ADDR_W-1:0] fault_addr;
   logic              fault_write;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #4 clk = ~clk;

   prot_region_guard uut (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_be (cfg_be), .cfg_wdata (cfg_wdata),
      .acc_valid (acc_valid), .acc_addr (acc_addr), .acc_write (acc_write), .acc_priv (acc_priv),
      .resp_valid (resp_valid), .resp_fault (resp_fault), .fault_seen (fault_seen),
      .fault_cause (fault_cause), .fault_addr (fault_addr), .fault_write (fault_write)
   );

   // {addr, priv, write, expected fault, expected cause}
   localparam logic [36:0] VEC [NVEC] = '{
      {32'h0000_1FFC, 1'b1, 1'b0, 1'b0, 2'b00}, // R6
      {32'h0000_1FFC, 1'b1, 1'b1, 1'b0, 2'b00}, // R6
      {32'h0000_1FFC, 1'b0, 1'b0, 1'b1, 2'b01}, // R6
      {32'h0000_1FFC, 1'b0, 1'b1, 1'b1, 2'b01}, // R6
      {32'h0000_2000, 1'b1, 1'b0, 1'b0, 2'b00}, // R7
      {32'h0000_2000, 1'b1, 1'b1, 1'b0, 2'b00}, // R7
      {32'h0000_2000, 1'b0, 1'b0, 1'b0, 2'b00}, // R7
      {32'h0000_2000, 1'b0, 1'b1, 1'b1, 2'b01}, // R7
      {32'h0000_3800, 1'b1, 1'b0, 1'b0, 2'b00}, // R8
      {32'h0000_3800, 1'b1, 1'b1, 1'b0, 2'b00}, // R8
      {32'h0000_3800, 1'b0, 1'b0, 1'b0, 2'b00}, // R8
      {32'h0000_3800, 1'b0, 1'b1, 1'b0, 2'b00}, // R8
      {32'h0000_4000, 1'b1, 1'b0, 1'b0, 2'b00}, // R9
      {32'h0000_4000, 1'b1, 1'b1, 1'b1, 2'b01}, // R9
      {32'h0000_4000, 1'b0, 1'b0, 1'b1, 2'b01}, // R9
      {32'h0000_4000, 1'b0, 1'b1, 1'b1, 2'b01}, // R9
      {32'h0000_5004, 1'b1, 1'b0, 1'b0, 2'b00}, // R9
      {32'h0000_5004, 1'b1, 1'b1, 1'b1, 2'b01}, // R9
      {32'h0000_5004, 1'b0, 1'b0, 1'b0, 2'b00}, // R9
      {32'h0000_5004, 1'b0, 1'b1, 1'b1, 2'b01}, // R9
      {32'h0000_6FFC, 1'b1, 1'b0, 1'b0, 2'b00}, // R9
      {32'h0000_6FFC, 1'b1, 1'b1, 1'b1, 2'b01}, // R9
      {32'h0000_6FFC, 1'b0, 1'b0, 1'b0, 2'b00}, // R9
      {32'h0000_6FFC, 1'b0, 1'b1, 1'b1, 2'b01}, // R9
      {32'h0000_7000, 1'b1, 1'b0, 1'b1, 2'b01}, // R5
      {32'h0000_7000, 1'b1, 1'b1, 1'b1, 2'b01}, // R5
      {32'h0000_7000, 1'b0, 1'b0, 1'b1, 2'b01}, // R5
      {32'h0000_7000, 1'b0, 1'b1, 1'b1, 2'b01}, // R5
      {32'h0000_8000, 1'b1, 1'b0, 1'b1, 2'b01}, // R5
      {32'h0000_8000, 1'b1, 1'b1, 1'b1, 2'b01}, // R5
      {32'h0000_8000, 1'b0, 1'b0, 1'b1, 2'b01}, // R5
      {32'h0000_8000, 1'b0, 1'b1, 1'b1, 2'b01}, // R5
      {32'h0000_9000, 1'b0, 1'b0, 1'b1, 2'b10}, // R3
      {32'h0000_0FFC, 1'b1, 1'b1, 1'b1, 2'b10}  // R3
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] off, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = off; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_be = '0;
   endtask

   // Drive at a falling edge, sample the registered answer at the next falling edge.
   task automatic access(input logic [31:0] a, input logic p, input logic w);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_priv = p; acc_write = w;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic prog_sel(input int r, input logic [31:0] base, input int n, input logic [2:0] perm);
      wr(6'h00, 4'hF, 32'(r));
      wr(6'h04, 4'hF, base);
      wr(6'h08, 4'b0011, (32'(n) << 1) | 32'h1);
      wr(6'h08, 4'b1100, 32'(perm) << 16);
   endtask

   task automatic prog_alias(input int slot, input int r, input logic [31:0] base, input int n,
                             input logic [2:0] perm);
      wr(6'(4 + 8 * slot), 4'hF, base | 32'h10 | 32'(r));
      wr(6'(8 + 8 * slot), 4'hF, (32'(perm) << 16) | (32'(n) << 1) | 32'h1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 resp_valid", 64'(resp_valid), 64'd0);
      chk("R1 fault_seen", 64'(fault_seen), 64'd0);
      chk("R1 fault_addr", 64'(fault_addr), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 idle no response", 64'(resp_valid), 64'd0);

      // R1/R3: nothing enabled, so every access is refused
      access(32'h0000_1234, 1'b1, 1'b0);
      chk("R2 resp_valid", 64'(resp_valid), 64'd1);
      chk("R1 R3 empty fault", 64'(resp_fault), 64'd1);
      chk("R3 cause nomatch", 64'(fault_cause), 64'd2);
      chk("R12 addr", 64'(fault_addr), 64'h1234);
      chk("R12 seen", 64'(fault_seen), 64'd1);
      chk("R12 write flag", 64'(fault_write), 64'd0);
      @(negedge clk);
      chk("R2 no resp after idle", 64'(resp_valid), 64'd0);

      // Program regions: N=11 gives a 4 KB span
      prog_sel(1, 32'h0000_1000, 11, 3'b001);
      prog_sel(2, 32'h0000_2000, 11, 3'b010);
      prog_sel(3, 32'h0000_3000, 11, 3'b011);
      prog_sel(4, 32'h0000_4000, 11, 3'b101);
      prog_alias(0, 5, 32'h0000_5000, 11, 3'b110);
      prog_alias(1, 6, 32'h0000_6000, 11, 3'b111);
      prog_alias(2, 7, 32'h0000_7000, 11, 3'b100);
      prog_alias(3, 0, 32'h0000_8000, 11, 3'b000);

      for (int i = 0; i < NVEC; i++) begin
         access(VEC[i][36:5], VEC[i][4], VEC[i][3]);
         chk($sformatf("R3-R9 R11 vector %0d fault", i), 64'(resp_fault), 64'(VEC[i][2]));
         if (VEC[i][2]) begin
            chk($sformatf("R12 vector %0d cause", i), 64'(fault_cause), 64'(VEC[i][1:0]));
            chk($sformatf("R12 vector %0d addr", i), 64'(fault_addr), 64'(VEC[i][36:5]));
            chk($sformatf("R12 vector %0d dir", i), 64'(fault_write), 64'(VEC[i][3]));
         end
      end

      // R12: an allowed access leaves the last fault status alone
      access(32'h0000_3000, 1'b0, 1'b1);
      chk("R12 allowed", 64'(resp_fault), 64'd0);
      chk("R12 addr kept", 64'(fault_addr), 64'h0FFC);
      chk("R12 cause kept", 64'(fault_cause), 64'd2);

      // R10: halfword writes on region 5
      wr(6'h00, 4'hF, 32'd5);
      wr(6'h08, 4'b1100, 32'(3'b011) << 16);
      access(32'h0000_5000, 1'b0, 1'b1);
      chk("R10 attr halfword keeps size", 64'(resp_fault), 64'd0);
      wr(6'h08, 4'b0011, 32'(11) << 1);
      access(32'h0000_5000, 1'b0, 1'b0);
      chk("R10 R3 disabled region", 64'(resp_fault), 64'd1);
      chk("R10 R3 disabled cause", 64'(fault_cause), 64'd2);
      wr(6'h08, 4'b0011, (32'(11) << 1) | 32'h1);
      access(32'h0000_5000, 1'b0, 1'b1);
      chk("R10 size halfword keeps attr", 64'(resp_fault), 64'd0);

      // R4: region 0 grown to the whole space with full access
      prog_alias(1, 0, 32'h0000_0000, 31, 3'b011);
      access(32'h0000_9000, 1'b0, 1'b1);
      chk("R4 R3 large span", 64'(resp_fault), 64'd0);
      access(32'h0000_7000, 1'b0, 1'b0);
      chk("R4 higher reserved wins", 64'(resp_fault), 64'd1);
      chk("R4 cause perm", 64'(fault_cause), 64'd1);
      access(32'h0000_1000, 1'b0, 1'b0);
      chk("R4 higher region 1 wins", 64'(resp_fault), 64'd1);

      // R11: retarget through the last alias, then a plain size word follows the new select
      wr(6'h1C, 4'hF, 32'h0000_A000 | 32'h10 | 32'd6);
      wr(6'h08, 4'hF, (32'(3'b111) << 16) | (32'(11) << 1) | 32'h1);
      access(32'h0000_A000, 1'b0, 1'b1);
      chk("R11 moved region write", 64'(resp_fault), 64'd1);
      access(32'h0000_A000, 1'b0, 1'b0);
      chk("R11 moved region read", 64'(resp_fault), 64'd0);
      access(32'h0000_6000, 1'b0, 1'b1);
      chk("R11 old span left", 64'(resp_fault), 64'd0);
      access(32'h0000_0400, 1'b0, 1'b1);
      chk("R11 region 0 untouched", 64'(resp_fault), 64'd0);

      finish_run();
   end

   initial begin
      #(8 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule